// File: doc/BRIEF.md
# Interval Timer Bus Interface and Command Decoder

This block sits between a processor bus and a three-channel interval timer. It watches a chip select, active-low read and write strobes, a 2-bit address and an 8-bit write data bus. It turns each completed access into one action. A write to a channel address loads count bytes. A write to the control address is decoded as one of three commands: channel programming, a count latch, or a read-back that can latch status and count for several channels at once. A read returns the selected channel's next count byte, or its latched status byte.

Each access is sampled on the system clock. It takes effect on the clock edge at which the qualified strobe is seen released, so a strobe held low for many cycles still acts once. The counting channels are kept deliberately simple. Each one holds its configuration, a count register, a counting element that steps down by one on every cycle its enable is high, an output latch, a status latch and a null-count flag.

Top module: `timer_bus_ctrl`

## Requirements
- R1: Read and write strobes have no effect, and reads return 0, unless `cs_n` is low while the strobe is low.
- R2: Address 0, 1 and 2 select channel 0, 1 and 2. Address 3 selects the control register.
- R3: An access acts once, on the first clock edge after the strobe (qualified by chip select) returns high, however long it was held low.
- R4: A control write with bits [7:6] = channel number 0..2 and bits [5:4] nonzero programs that channel. Bits [5:4] give the access order (01 low byte only, 10 high byte only, 11 low then high), bits [3:1] the mode and bit 0 the decimal flag. Programming clears the count register, clears pending latches and byte toggles, and sets null-count. Other channels are untouched.
- R5: Count writes follow the access order. A single-byte order loads the counting element at once with the written byte and a zero in the other byte. The low-then-high order loads only after the second byte. Every load clears null-count.
- R6: Count reads follow the access order. The low-then-high order returns the low byte first, then the high byte.
- R7: A control write with bits [5:4] = 00 and bits [7:6] = 0..2 freezes that channel's count in its output latch. The latch holds until the full count has been read. A further latch command while the latch is held is ignored.
- R8: A control write with bits [7:6] = 11 is a read-back. Bits [3:1] form a mask in which bit 1+i selects channel i. Bit 5 low latches count and bit 4 low latches status for every selected channel. Channels not selected are unaffected.
- R9: The status byte is {output level, null-count, access order[1:0], mode[2:0], decimal flag}, most significant bit first.
- R10: When status and count are both latched, the first read returns the status byte and the following reads return the latched count bytes.
- R11: The control register cannot be read: a read at address 3 returns 0 and changes nothing.
- R12: A channel's counting element steps down by one on each clock with its `cnt_en` bit high, and its output is high exactly when the element is zero (reset value zero).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Channel or control register select |
| wdata | input | 8 | Write data |
| cnt_en | input | 3 | Per-channel count-down enable for the stub counters |
| rdata | output | 8 | Read data, 0 when no channel read is active |
| chan_out | output | 3 | Per-channel output level |

## Verification
The bench builds the block with its defaults: three channels, 8-bit data and 16-bit counts. It sweeps every channel through every access order, modes 0 to 5 and both decimal settings. After each programming step it reads the status back and the count bytes in order, with the expected values computed from a running model of each counting element. Directed sequences then cover the freeze-until-fully-read latch, combined status-and-count read-back on a subset of channels, strobes held low for several cycles, chip-select gating, reads of the control address, and count-down to zero.

// File: rtl/timer_bus_pkg.sv
package timer_bus_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

endpackage

// File: rtl/timer_bus_strobe.sv
module timer_bus_strobe #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          stb_n,
  input  logic [AW-1:0] addr,
  output logic          act,
  output logic          done,
  output logic [AW-1:0] addr_q
);

  logic act_q;

  always_comb begin
    act  = ~cs_n & ~stb_n;
    done = act_q & ~act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      act_q <= act;
      if (act) addr_q <= addr;
    end
  end

endmodule

// File: rtl/timer_bus_decode.sv
module timer_bus_decode
  import timer_bus_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2,
  parameter int DW  = 8
) (
  input  logic          wr_done,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_done,
  input  logic [AW-1:0] rd_addr,
  output chan_cfg_t     cfg_new,
  output logic          is_prog,
  output logic          is_latch,
  output logic          is_rb,
  output logic [NCH-1:0] prog,
  output logic [NCH-1:0] cnt_latch,
  output logic [NCH-1:0] sts_latch,
  output logic [NCH-1:0] cnt_wr,
  output logic [NCH-1:0] cnt_rd
);

  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  logic       ctl_wr;
  logic [1:0] sel;
  logic [1:0] acc;

  always_comb begin
    ctl_wr   = wr_done && (wr_addr == CTRL_ADDR);
    sel      = wr_data[7:6];
    acc      = wr_data[5:4];
    cfg_new  = chan_cfg_t'(wr_data[CFG_W-1:0]);
    is_rb    = ctl_wr && (sel == 2'b11);
    is_prog  = ctl_wr && (sel != 2'b11) && (acc != 2'b00);
    is_latch = ctl_wr && (sel != 2'b11) && (acc == 2'b00);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    always_comb begin
      prog[i]      = is_prog && (sel == 2'(i));
      cnt_latch[i] = (is_latch && (sel == 2'(i))) ||
                     (is_rb && !wr_data[5] && wr_data[1+i]);
      sts_latch[i] = is_rb && !wr_data[4] && wr_data[1+i];
      cnt_wr[i]    = wr_done && (wr_addr == AW'(i));
      cnt_rd[i]    = rd_done && (rd_addr == AW'(i));
    end
  end

endmodule

// File: rtl/timer_bus_chan.sv
module timer_bus_chan
  import timer_bus_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  chan_cfg_t     cfg_in,
  input  logic          cnt_latch,
  input  logic          sts_latch,
  input  logic          cnt_wr,
  input  logic [DW-1:0] wr_byte,
  input  logic          cnt_rd,
  input  logic          cnt_en,
  output logic [DW-1:0] rd_byte,
  output logic          out,
  output logic          null_cnt
);

  localparam int HI = CNT_W - 1;
  localparam int LO = CNT_W - DW;

  chan_cfg_t        cfg_q, cfg_d;
  logic [CNT_W-1:0] cr_q, cr_d;
  logic [CNT_W-1:0] ce_q, ce_d;
  logic [CNT_W-1:0] ol_q, ol_d;
  logic             ol_vld_q, ol_vld_d;
  logic [DW-1:0]    sts_q, sts_d;
  logic             sts_vld_q, sts_vld_d;
  logic             wr_hi_q, wr_hi_d;
  logic             rd_hi_q, rd_hi_d;
  logic             null_q, null_d;
  logic [CNT_W-1:0] view;

  always_comb begin
    out      = (ce_q == '0);
    null_cnt = null_q;
    view     = ol_vld_q ? ol_q : ce_q;
    if (sts_vld_q) begin
      rd_byte = sts_q;
    end else begin
      unique case (cfg_q.acc)
        ACC_LO:   rd_byte = view[DW-1:0];
        ACC_HI:   rd_byte = view[HI:LO];
        ACC_WORD: rd_byte = rd_hi_q ? view[HI:LO] : view[DW-1:0];
        default:  rd_byte = '0;
      endcase
    end
  end

  always_comb begin
    cfg_d     = cfg_q;
    cr_d      = cr_q;
    ce_d      = cnt_en ? ce_q - CNT_W'(1) : ce_q;
    ol_d      = ol_q;
    ol_vld_d  = ol_vld_q;
    sts_d     = sts_q;
    sts_vld_d = sts_vld_q;
    wr_hi_d   = wr_hi_q;
    rd_hi_d   = rd_hi_q;
    null_d    = null_q;
    if (prog) begin
      cfg_d     = cfg_in;
      cr_d      = '0;
      null_d    = 1'b1;
      wr_hi_d   = 1'b0;
      rd_hi_d   = 1'b0;
      ol_vld_d  = 1'b0;
      sts_vld_d = 1'b0;
    end else begin
      if (cnt_wr) begin
        unique case (cfg_q.acc)
          ACC_LO: begin
            cr_d[DW-1:0] = wr_byte;
            ce_d         = cr_d;
            null_d       = 1'b0;
          end
          ACC_HI: begin
            cr_d[HI:LO] = wr_byte;
            ce_d        = cr_d;
            null_d      = 1'b0;
          end
          ACC_WORD: begin
            if (!wr_hi_q) begin
              cr_d[DW-1:0] = wr_byte;
              wr_hi_d      = 1'b1;
            end else begin
              cr_d[HI:LO] = wr_byte;
              wr_hi_d     = 1'b0;
              ce_d        = cr_d;
              null_d      = 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (cnt_rd) begin
        if (sts_vld_q) begin
          sts_vld_d = 1'b0;
        end else begin
          unique case (cfg_q.acc)
            ACC_LO, ACC_HI: ol_vld_d = 1'b0;
            ACC_WORD: begin
              rd_hi_d = ~rd_hi_q;
              if (rd_hi_q) ol_vld_d = 1'b0;
            end
            default: ;
          endcase
        end
      end
      if (cnt_latch && !ol_vld_q) begin
        ol_d     = ce_q;
        ol_vld_d = 1'b1;
      end
      if (sts_latch && !sts_vld_q) begin
        sts_d     = {out, null_q, cfg_q};
        sts_vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cr_q      <= '0;
      ce_q      <= '0;
      ol_q      <= '0;
      ol_vld_q  <= 1'b0;
      sts_q     <= '0;
      sts_vld_q <= 1'b0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      null_q    <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      cr_q      <= cr_d;
      ce_q      <= ce_d;
      ol_q      <= ol_d;
      ol_vld_q  <= ol_vld_d;
      sts_q     <= sts_d;
      sts_vld_q <= sts_vld_d;
      wr_hi_q   <= wr_hi_d;
      rd_hi_q   <= rd_hi_d;
      null_q    <= null_d;
    end
  end

endmodule

// File: rtl/timer_bus_ctrl.sv
module timer_bus_ctrl
  import timer_bus_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int AW    = 2,
  parameter int DW    = 8,
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] cnt_en,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] chan_out
);

  logic           wr_act, wr_done, rd_act, rd_done;
  logic [AW-1:0]  wr_addr_q, rd_addr_q;
  logic [DW-1:0]  wr_data_q;
  chan_cfg_t      cfg_new;
  logic           is_prog, is_latch, is_rb;
  logic [NCH-1:0] prog_v, cnt_latch_v, sts_latch_v, cnt_wr_v, cnt_rd_v;
  logic [NCH-1:0] chan_null;
  logic [DW-1:0]  chan_rd [NCH];

  timer_bus_strobe #(.AW(AW)) u_wr_stb (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .stb_n(wr_n), .addr(addr),
    .act(wr_act), .done(wr_done), .addr_q(wr_addr_q)
  );

  timer_bus_strobe #(.AW(AW)) u_rd_stb (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .stb_n(rd_n), .addr(addr),
    .act(rd_act), .done(rd_done), .addr_q(rd_addr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_data_q <= '0;
    else if (wr_act) wr_data_q <= wdata;
  end

  timer_bus_decode #(.NCH(NCH), .AW(AW), .DW(DW)) u_dec (
    .wr_done(wr_done), .wr_addr(wr_addr_q), .wr_data(wr_data_q),
    .rd_done(rd_done), .rd_addr(rd_addr_q),
    .cfg_new(cfg_new), .is_prog(is_prog), .is_latch(is_latch), .is_rb(is_rb),
    .prog(prog_v), .cnt_latch(cnt_latch_v), .sts_latch(sts_latch_v),
    .cnt_wr(cnt_wr_v), .cnt_rd(cnt_rd_v)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    timer_bus_chan #(.DW(DW), .CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .prog(prog_v[i]), .cfg_in(cfg_new),
      .cnt_latch(cnt_latch_v[i]), .sts_latch(sts_latch_v[i]),
      .cnt_wr(cnt_wr_v[i]), .wr_byte(wr_data_q),
      .cnt_rd(cnt_rd_v[i]), .cnt_en(cnt_en[i]),
      .rd_byte(chan_rd[i]), .out(chan_out[i]), .null_cnt(chan_null[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_act && (addr == AW'(i))) rdata = chan_rd[i];
    end
  end

endmodule

// File: rtl/timer_bus_chk.sv
module timer_bus_chk #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata,
  input logic          wr_done,
  input logic          is_prog,
  input logic          is_latch,
  input logic          is_rb,
  input logic          prog0,
  input logic          null0
);

  AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> $past(!cs_n && !wr_n)); // R1

  AST_CMD_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_prog || is_latch || is_rb) |-> (cs_n || wr_n)); // R3

  AST_CTRL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_prog || is_latch || is_rb) |-> ($past(addr) == AW'(3))); // R2

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_prog, is_latch, is_rb})); // R4

  AST_NULL_ON_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    prog0 |=> null0); // R4

  AST_NO_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n || addr == AW'(3)) |-> (rdata == '0)); // R11

endmodule

bind timer_bus_ctrl timer_bus_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .addr(addr), .rdata(rdata), .wr_done(wr_done), .is_prog(is_prog),
  .is_latch(is_latch), .is_rb(is_rb), .prog0(prog_v[0]), .null0(chan_null[0])
);

// File: tb/tb_timer_bus_ctrl.sv
module tb_timer_bus_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, cs_n, rd_n, wr_n;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic [2:0] cnt_en, chan_out;

  int n_chk, n_fail;
  bit done;

  logic [15:0] m_ce  [3];
  logic [1:0]  m_acc [3];
  logic [2:0]  m_mode[3];
  logic        m_bcd [3];
  logic        m_null[3];

  timer_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .cnt_en(cnt_en), .rdata(rdata),
    .chan_out(chan_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input int hold = 1, input logic sel_n = 1'b0);
    @(negedge clk);
    cs_n = sel_n; addr = a; wdata = d; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, input int hold = 1);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_n = 1'b0;
    repeat (hold) @(negedge clk);
    d = rdata;
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic count(input logic [2:0] en, input int n);
    @(negedge clk);
    cnt_en = en;
    repeat (n) @(negedge clk);
    cnt_en = 3'b000;
    for (int i = 0; i < 3; i++) if (en[i]) m_ce[i] = m_ce[i] - 16'(n);
  endtask

  function automatic logic [7:0] exp_sts(input int c);
    return {m_ce[c] == 16'h0, m_null[c], m_acc[c], m_mode[c], m_bcd[c]};
  endfunction

  task automatic program_ch(input int c, input logic [1:0] acc, input logic [2:0] mode, input logic bcd);
    bus_wr(2'd3, {2'(c), acc, mode, bcd});
    m_acc[c] = acc; m_mode[c] = mode; m_bcd[c] = bcd; m_null[c] = 1'b1;
  endtask

  task automatic load_ch(input int c, input logic [15:0] v);
    case (m_acc[c])
      2'b01: begin bus_wr(2'(c), v[7:0]);  m_ce[c] = {8'h00, v[7:0]}; end
      2'b10: begin bus_wr(2'(c), v[15:8]); m_ce[c] = {v[15:8], 8'h00}; end
      default: begin
        bus_wr(2'(c), v[7:0]); bus_wr(2'(c), v[15:8]); m_ce[c] = v;
      end
    endcase
    m_null[c] = 1'b0;
  endtask

  task automatic sts_read_check(input int c, input string tag);
    logic [7:0] d;
    bus_wr(2'd3, 8'hE0 | (8'(1 << c) << 1));
    bus_rd(2'(c), d);
    check(tag, {8'h0, d}, {8'h0, exp_sts(c)});
  endtask

  initial begin
    logic [7:0] d;
    logic [15:0] v;
    n_chk = 0; n_fail = 0; done = 1'b0;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = 2'd0; wdata = 8'h00; cnt_en = 3'b000;
    for (int i = 0; i < 3; i++) begin
      m_ce[i] = 16'h0; m_acc[i] = 2'b00; m_mode[i] = 3'd0; m_bcd[i] = 1'b0; m_null[i] = 1'b0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset rdata R11", {8'h0, rdata}, 16'h0);
    check("reset out R12", {13'h0, chan_out}, 16'h7);

    // R2 R4 R5 R6 R9: sweep of channel, access order, mode and decimal flag
    for (int c = 0; c < 3; c++)
      for (int acc = 1; acc < 4; acc++)
        for (int mode = 0; mode < 6; mode++)
          for (int bcd = 0; bcd < 2; bcd++) begin
            program_ch(c, 2'(acc), 3'(mode), 1'(bcd));
            sts_read_check(c, "sweep status after programming R4 R9");
            v = 16'(c * 4099 + acc * 771 + mode * 1237 + bcd * 97 + 1);
            load_ch(c, v);
            if (acc == 3) begin
              bus_rd(2'(c), d); check("sweep word low byte R6 R2", {8'h0, d}, {8'h0, m_ce[c][7:0]});
              bus_rd(2'(c), d); check("sweep word high byte R6 R2", {8'h0, d}, {8'h0, m_ce[c][15:8]});
            end else begin
              bus_rd(2'(c), d);
              check("sweep single byte R5 R2", {8'h0, d},
                    {8'h0, (acc == 1) ? m_ce[c][7:0] : m_ce[c][15:8]});
            end
            sts_read_check(c, "sweep status after load R5 R9");
          end

    // R4: channels programmed independently
    program_ch(0, 2'b01, 3'd2, 1'b0);
    program_ch(1, 2'b10, 3'd4, 1'b1);
    program_ch(2, 2'b11, 3'd1, 1'b0);
    bus_wr(2'd3, 8'hEE);
    for (int c = 0; c < 3; c++) begin
      bus_rd(2'(c), d);
      check("independent status R4", {8'h0, d}, {8'h0, exp_sts(c)});
    end
    load_ch(0, 16'h0021);
    load_ch(1, 16'h9A00);
    load_ch(2, 16'h1234);

    // R7: count latch on channel 2 holds until both bytes read
    bus_wr(2'd3, 8'h80);
    count(3'b100, 10);
    bus_rd(2'd2, d); check("latched low R7", {8'h0, d}, 16'h0034);
    bus_wr(2'd3, 8'h80);
    count(3'b100, 3);
    bus_rd(2'd2, d); check("latched high R7", {8'h0, d}, 16'h0012);
    bus_rd(2'd2, d); check("live low after latch R7", {8'h0, d}, {8'h0, m_ce[2][7:0]});
    bus_rd(2'd2, d); check("live high after latch R7", {8'h0, d}, {8'h0, m_ce[2][15:8]});

    // R8 R10: read-back of status and count on channels 0 and 1
    bus_wr(2'd3, 8'hC6);
    v = {m_ce[1][15:8], m_ce[0][7:0]};
    d = exp_sts(0);
    count(3'b011, 5);
    bus_rd(2'd0, rdata_tmp); check("readback ch0 status first R10 R9", {8'h0, rdata_tmp}, {8'h0, d});
    bus_rd(2'd0, rdata_tmp); check("readback ch0 latched count R8", {8'h0, rdata_tmp}, {8'h0, v[7:0]});
    bus_rd(2'd0, rdata_tmp); check("readback ch0 live after R8", {8'h0, rdata_tmp}, {8'h0, m_ce[0][7:0]});
    bus_rd(2'd1, rdata_tmp); check("readback ch1 status first R10 R9", {8'h0, rdata_tmp}, 16'h0029);
    bus_rd(2'd1, rdata_tmp); check("readback ch1 latched count R8", {8'h0, rdata_tmp}, {8'h0, v[15:8]});
    bus_rd(2'd1, rdata_tmp); check("readback ch1 live after R8", {8'h0, rdata_tmp}, {8'h0, m_ce[1][15:8]});
    bus_rd(2'd2, rdata_tmp); check("unmasked ch2 unaffected R8", {8'h0, rdata_tmp}, {8'h0, m_ce[2][7:0]});
    bus_rd(2'd2, rdata_tmp);

    // R1: strobes without chip select
    bus_wr(2'd3, 8'h36, 1, 1'b1);
    bus_wr(2'd0, 8'h77, 1, 1'b1);
    sts_read_check(0, "program without select ignored R1");
    bus_rd(2'd0, d); check("count write without select ignored R1", {8'h0, d}, {8'h0, m_ce[0][7:0]});
    @(negedge clk); rd_n = 1'b0; addr = 2'd0; @(negedge clk);
    check("read without select returns 0 R1", {8'h0, rdata}, 16'h0);
    rd_n = 1'b1;

    // R3: held strobes act once
    bus_wr(2'd2, 8'hCD, 4);
    bus_wr(2'd2, 8'hAB, 5);
    m_ce[2] = 16'hABCD;
    bus_rd(2'd2, d, 4); check("held read low R3", {8'h0, d}, 16'h00CD);
    bus_rd(2'd2, d, 3); check("held read high R3", {8'h0, d}, 16'h00AB);

    // R11: control address read
    bus_rd(2'd3, d); check("control read is 0 R11", {8'h0, d}, 16'h0);
    bus_rd(2'd2, d); check("control read changed nothing R11", {8'h0, d}, 16'h00CD);
    bus_rd(2'd2, d);

    // R12: count down to zero drives output high
    count(3'b001, int'(m_ce[0]) - 1);
    check("out low before zero R12", {15'h0, chan_out[0]}, 16'h0);
    count(3'b001, 1);
    check("out high at zero R12", {15'h0, chan_out[0]}, 16'h1);
    sts_read_check(0, "status out bit at zero R12 R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [7:0] rdata_tmp;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule